// File: doc/BRIEF.md
# Generalized Bit-Reverse Permutation Unit

This unit permutes the bits of an operand. Each bit of the result is taken from the operand bit whose index is the result index XORed with a control value. A single control value therefore produces a family of patterns. Setting every control bit gives a full bit reversal. Setting only the upper control bits swaps bytes or nibbles. A zero control value leaves the operand unchanged. The control value comes either from a register operand or from a short immediate, and both sources behave the same way.

A word mode permutes only the lower half of the operand and clears the upper half of the result. When the record flag is set, a condition field is written from the result: less-than, greater-than and equal from a signed compare with zero, plus a summary-overflow bit copied from an input. The permutation is a chain of log2(XLEN) conditional block-swap stages. The result and the condition field are registered, so they appear one clock after the inputs.

Top module: `gbr_unit`

## Requirements
- R1: In full mode (`word_i`=0), one clock after the inputs are applied, `res_o[i]` equals `a_i[(c XOR i) mod XLEN]` for every i, where c is the selected control value.
- R2: With `imm_sel_i`=0 the control value is `rb_i`; with `imm_sel_i`=1 it is `imm_i` zero-extended. Equal control values give equal results from either source.
- R3: In word mode (`word_i`=1), `res_o[i]` equals `a_i[(c XOR i) mod (XLEN/2)]` for i below XLEN/2.
- R4: In word mode, bits XLEN/2 and above of `res_o` are zero.
- R5: Only the low log2(XLEN) control bits act in full mode, and only the low log2(XLEN/2) bits in word mode. Higher control bits have no effect on the result.
- R6: A control value of zero gives the operand unchanged. A control value with all active bits set reverses the bit order within the active width.
- R7: When `rec_i`=1, one clock later `cr0_o` = {LT, GT, EQ, SO}. Bit 3 is set when the result is negative as a signed value. Bit 2 is set when it is positive. Bit 1 is set when it is zero. Bit 0 is the sampled `so_i`.
- R8: When `rec_i`=0, `cr0_o` keeps its previous value.
- R9: While `rst_ni` is low, `res_o` and `cr0_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | XLEN | Operand to permute |
| rb_i | input | XLEN | Register control value |
| imm_i | input | log2(XLEN) | Immediate control value |
| imm_sel_i | input | 1 | 1 selects the immediate control |
| word_i | input | 1 | 1 selects word (half-width) mode |
| rec_i | input | 1 | 1 updates the condition field |
| so_i | input | 1 | Summary-overflow bit copied into the condition field |
| res_o | output | XLEN | Registered permutation result |
| cr0_o | output | 4 | Registered condition field {LT, GT, EQ, SO} |

## Verification
The hardest case to reach is a register control value whose high bits are set while the low bits form a structured pattern such as a byte swap. Random 64-bit register values almost never carry a low field of zero or all ones, so they rarely expose a stage that wrongly reads a high control bit. Directed cases fill the upper bits of `rb_i` with ones and pair them with identity, reversal and byte-swap low fields in both modes. Random cases also pit the immediate against an equal register value. Negative, positive and zero results are forced through the condition field, with and without the record flag.

// File: rtl/gbr_pkg.sv
package gbr_pkg;
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_t;
endpackage

// File: rtl/gbr_swap_stage.sv
module gbr_swap_stage #(
  parameter int W = 64,
  parameter int K = 0
) (
  input  logic [W-1:0] in_i,
  input  logic         sel_i,
  output logic [W-1:0] out_o
);
  localparam int BLK = 1 << K;

  // swap each pair of adjacent BLK-bit blocks when selected
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign out_o[i] = sel_i ? in_i[i ^ BLK] : in_i[i];
  end
endmodule

// File: rtl/gbr_butterfly.sv
module gbr_butterfly #(
  parameter int W = 64,
  localparam int LOG = $clog2(W)
) (
  input  logic [W-1:0]   a_i,
  input  logic [LOG-1:0] ctl_i,
  output logic [W-1:0]   y_o
);
  logic [W-1:0] stage_d [LOG+1];

  assign stage_d[0] = a_i;

  for (genvar k = 0; k < LOG; k++) begin : g_stage
    gbr_swap_stage #(.W(W), .K(k)) i_stage (
      .in_i (stage_d[k]),
      .sel_i(ctl_i[k]),
      .out_o(stage_d[k+1])
    );
  end

  assign y_o = stage_d[LOG];
endmodule

// File: rtl/gbr_cond.sv
module gbr_cond
  import gbr_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] res_i,
  input  logic         so_i,
  output cr_t          cr_o
);
  logic zero;

  assign zero    = (res_i == '0);
  assign cr_o.lt = res_i[W-1];
  assign cr_o.eq = zero;
  assign cr_o.gt = !res_i[W-1] && !zero;
  assign cr_o.so = so_i;
endmodule

// File: rtl/gbr_unit.sv
module gbr_unit
  import gbr_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int LOG = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] rb_i,
  input  logic [LOG-1:0]  imm_i,
  input  logic            imm_sel_i,
  input  logic            word_i,
  input  logic            rec_i,
  input  logic            so_i,
  output logic [XLEN-1:0] res_o,
  output logic [3:0]      cr0_o
);
  logic [LOG-1:0]  ctl_sel;
  logic [LOG-1:0]  ctl_eff;
  logic [XLEN-1:0] perm;
  logic [XLEN-1:0] res_d;
  cr_t             cr_d;
  cr_t             cr_q;
  logic            pv_q;

  assign ctl_sel = imm_sel_i ? imm_i : rb_i[LOG-1:0];
  // word mode: top stage off keeps the low half inside itself
  assign ctl_eff = word_i ? {1'b0, ctl_sel[LOG-2:0]} : ctl_sel;

  gbr_butterfly #(.W(XLEN)) i_bfly (
    .a_i  (a_i),
    .ctl_i(ctl_eff),
    .y_o  (perm)
  );

  assign res_d = word_i ? {{HALF{1'b0}}, perm[HALF-1:0]} : perm;

  gbr_cond #(.W(XLEN)) i_cond (
    .res_i(res_d),
    .so_i (so_i),
    .cr_o (cr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      cr_q  <= '0;
      pv_q  <= 1'b0;
    end else begin
      res_o <= res_d;
      pv_q  <= 1'b1;
      if (rec_i) cr_q <= cr_d;
    end
  end

  assign cr0_o = cr_q;

  p_word_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q && $past(word_i) |-> res_o[XLEN-1:HALF] == '0);

  p_full_popcount_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q && !$past(word_i) |-> $countones(res_o) == $countones($past(a_i)));

  p_zero_ctl_identity_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q && !$past(word_i) &&
    $past(imm_sel_i ? (imm_i == '0) : (rb_i[LOG-1:0] == '0)) |-> res_o == $past(a_i));

  p_cr_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q && $past(rec_i) |-> $countones(cr0_o[3:1]) == 1);

  p_cr_so_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q && $past(rec_i) |-> cr0_o[0] == $past(so_i));

  p_cr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q && !$past(rec_i) |-> $stable(cr0_o));
endmodule

// File: tb/test_gbr_unit.sv
module test_gbr_unit;
  localparam int XLEN = 64;
  localparam int LOG = 6;
  localparam int HALF = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [XLEN-1:0] a_i = '0;
  logic [XLEN-1:0] rb_i = '0;
  logic [LOG-1:0]  imm_i = '0;
  logic            imm_sel_i = 1'b0;
  logic            word_i = 1'b0;
  logic            rec_i = 1'b0;
  logic            so_i = 1'b0;
  logic [XLEN-1:0] res_o;
  logic [3:0]      cr0_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [3:0] exp_cr = '0;

  always #2 clk_i = ~clk_i;

  gbr_unit #(.XLEN(XLEN)) i_gbr_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .rb_i(rb_i), .imm_i(imm_i),
    .imm_sel_i(imm_sel_i), .word_i(word_i), .rec_i(rec_i), .so_i(so_i),
    .res_o(res_o), .cr0_o(cr0_o)
  );

  function automatic logic [XLEN-1:0] ref_perm(logic [XLEN-1:0] a, logic [XLEN-1:0] c,
                                               bit word);
    logic [XLEN-1:0] r = '0;
    for (int i = 0; i < XLEN; i++) begin
      if (word) begin
        if (i < HALF) r[i] = a[(c ^ XLEN'(i)) % HALF];
      end else begin
        r[i] = a[(c ^ XLEN'(i)) % XLEN];
      end
    end
    return r;
  endfunction

  function automatic logic [XLEN-1:0] rev_bits(logic [XLEN-1:0] a, int w);
    logic [XLEN-1:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = a[w-1-i];
    return r;
  endfunction

  function automatic logic [3:0] ref_cr(logic [XLEN-1:0] r, bit so);
    logic signed [XLEN-1:0] s = r;
    return {s < 0, s > 0, s == 0, so};
  endfunction

  task automatic chk(bit ok, string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check at next negedge (one register of latency)
  task automatic run(logic [XLEN-1:0] a, logic [XLEN-1:0] rb, logic [LOG-1:0] imm,
                     bit isel, bit word, bit rec, bit so,
                     logic [XLEN-1:0] exp, string req);
    @(negedge clk_i);
    a_i = a; rb_i = rb; imm_i = imm; imm_sel_i = isel;
    word_i = word; rec_i = rec; so_i = so;
    if (rec) exp_cr = ref_cr(exp, so);
    @(negedge clk_i);
    chk(res_o === exp, req, res_o, exp);
    chk(cr0_o === exp_cr, rec ? "R7 cr0" : "R8 cr0 hold", XLEN'(cr0_o), XLEN'(exp_cr));
  endtask

  initial begin
    logic [XLEN-1:0] pat = 64'h0123_4567_89AB_CDEF;
    void'($urandom(32'd20931));
    #1;
    chk(res_o === '0, "R9 res reset", res_o, '0);
    chk(cr0_o === '0, "R9 cr0 reset", XLEN'(cr0_o), '0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    run(pat, '0, '0, 0, 0, 1, 0, pat, "R6 identity full");
    run(pat, 64'd63, '0, 0, 0, 1, 1, rev_bits(pat, XLEN), "R6 reversal full");
    run(pat, 64'd31, '0, 0, 1, 1, 0, rev_bits(pat, HALF), "R6 reversal word");
    run(pat, 64'd56, '0, 0, 0, 0, 0, 64'hEFCD_AB89_6745_2301, "R1 byte swap");
    run(pat, 64'd4, '0, 0, 0, 1, 0, 64'h1032_5476_98BA_DCFE, "R1 nibble swap");
    run(pat, {58'h3FF_FFFF_FFFF_FFFF, 6'd56}, '0, 0, 0, 1, 1,
        64'hEFCD_AB89_6745_2301, "R5 high rb bits ignored full");
    run(pat, {58'h3FF_FFFF_FFFF_FFFF, 6'd32}, '0, 0, 1, 0, 1,
        {32'h0, pat[31:0]}, "R5 bit5 ignored word");
    run(pat, '0, 6'd56, 1, 0, 1, 0, 64'hEFCD_AB89_6745_2301, "R2 immediate byte swap");
    run(pat, 64'hFFFF_0000_0000_0000, 6'd63, 1, 0, 0, 0,
        rev_bits(pat, XLEN), "R2 immediate overrides rb");
    run(64'hFFFF_FFFF_0000_0000, '0, 6'd0, 1, 1, 1, 0, '0, "R4 word upper zero");
    run(64'h8000_0000_0000_0000, '0, 6'd0, 1, 0, 1, 0,
        64'h8000_0000_0000_0000, "R7 negative result");

    for (int n = 0; n < 400; n++) begin
      logic [XLEN-1:0] a = {$urandom, $urandom};
      logic [XLEN-1:0] rb = {$urandom, $urandom};
      logic [LOG-1:0] imm = LOG'($urandom);
      bit isel = 1'($urandom);
      bit word = 1'($urandom);
      bit rec = 1'($urandom);
      bit so = 1'($urandom);
      logic [XLEN-1:0] c = isel ? XLEN'(imm) : rb;
      logic [XLEN-1:0] e = ref_perm(a, c, word);
      if (n % 8 == 0) a = '0;
      if (n % 8 == 0) e = '0;
      run(a, rb, imm, isel, word, rec, so, e, word ? "R3 word random" : "R1 full random");
      if (isel) begin
        run(a, {$urandom, $urandom} << LOG | XLEN'(imm), imm, 0, word, rec, so, e,
            "R2 rb matches immediate");
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule